// File: doc/BRIEF.md
# Double-Buffered Profile Register Port

This block is the host-facing programming front end of a frequency synthesizer core. A host drives an 8-bit bidirectional data bus, a 6-bit address bus and separate read and write strobes. Every write goes into a staging copy of the register file. The synthesizer core sees only the active copy. The active copy takes the whole staging copy in one step when the update input rises, or when the two profile select inputs change.

The register space has a global region and a profile region. The global region holds eight bytes at addresses 0x00 to 0x07, and the profile pins do not affect it. The profile region is a window of eight bytes at 0x08 to 0x0F. The two profile pins select which of four banks appears in that window, and bits [2:0] of the address give the byte offset inside the bank. Readback returns the staged contents. When the mode input is low, the parallel port is inactive: serial programming owns the register file, and that port is handled elsewhere. The core reads the active global bytes, the active bytes of the selected bank, and the index of that bank.

Top module: `profreg_port`

## Requirements
- R1: After reset, every staged and active byte is 0x00, `err` is low and `act_bank` is 0. The bus is driven only during a read.
- R2: A write with `par_mode`=1, `wr`=1, `rd`=0 stores the bus byte in the staging copy at the rising clock edge. A read returns it at once, but `act_glb` and `act_prf` do not change until a commit.
- R3: A rising edge on `upd` copies the whole staging copy into the active copy. The outputs show the new values after the third rising clock edge counted from the pin change, and not after the second. A level held high or a falling edge causes no commit.
- R4: A change of `prof_sel` also commits the whole staging copy, with the same three-edge latency. `act_bank` follows the new selection at the same edge, and `act_prf` shows the active bytes of that bank (byte k at bits [8k+7:8k]).
- R5: Addresses 0x08 to 0x0F reach byte `addr[2:0]` of the bank named by the current `prof_sel` pins, for both writes and reads. Different banks hold independent values.
- R6: With `par_mode`=0, writes are ignored and the data bus is not driven.
- R7: When `rd` and `wr` are both high in parallel mode, nothing is written, the bus is not driven, and `err` is high for the clock cycle after that edge.
- R8: The block drives the data bus only while `par_mode`=1, `rd`=1 and `wr`=0. At all other times the bus is high impedance.
- R9: Addresses 0x10 to 0x3F are unmapped. Reads return 0x00, and writes change no mapped byte.
- R10: Addresses 0x00 to 0x07 reach the same global byte whatever the `prof_sel` pins are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| par_mode | input | 1 | 1 enables the parallel port, 0 leaves it idle |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 6 | Register address |
| data_io | inout | 8 | Bidirectional data bus |
| prof_sel | input | 2 | Profile bank select pins |
| upd | input | 1 | Commit request, acts on its rising edge |
| err | output | 1 | Pulses after an edge that saw both strobes high |
| act_glb | output | 64 | Active global bytes, byte k at [8k+7:8k] |
| act_prf | output | 64 | Active bytes of the selected bank |
| act_bank | output | 2 | Bank index the active outputs reflect |

## Verification
The assertions check on every cycle that the active global bytes stay unchanged unless a commit is pending. They also check that the staging copy stays untouched by writes in serial mode, by writes to unmapped addresses and by conflicting strobes, that the bus is driven only for a clean parallel read, and that the error pulse appears exactly after a strobe conflict. Only the bench scenarios can show the commit latency of three edges, that held levels and falling edges of the update pin do not commit, that banks are independent under the profile window, and that data written in one profile setting reads back correctly.

// File: rtl/profreg_port.sv
module profreg_port #(
  parameter int DW        = 8,
  parameter int AW        = 6,
  parameter int GLB_BYTES = 8,
  parameter int PRF_BYTES = 8,
  parameter int NPROF     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         par_mode,
  input  logic                         rd,
  input  logic                         wr,
  input  logic [AW-1:0]                addr,
  inout  wire  [DW-1:0]                data_io,
  input  logic [$clog2(NPROF)-1:0]     prof_sel,
  input  logic                         upd,
  output logic                         err,
  output logic [GLB_BYTES*DW-1:0]      act_glb,
  output logic [PRF_BYTES*DW-1:0]      act_prf,
  output logic [$clog2(NPROF)-1:0]     act_bank
);
  localparam int PW     = $clog2(NPROF);
  localparam int NBYTES = GLB_BYTES + PRF_BYTES * NPROF;
  localparam int IW     = $clog2(NBYTES);
  localparam int MAPPED = GLB_BYTES + PRF_BYTES;

  logic [NBYTES-1:0][DW-1:0] stg, act;
  logic [31:0] a32, lin;
  logic [IW-1:0] idx;
  logic glb_hit, prf_hit, hit;
  logic wr_ok, drv;
  logic [DW-1:0] rdata;

  logic [1:0]    upd_s;
  logic          upd_q;
  logic [PW-1:0] prf_s1, prf_s2;
  logic          commit;

  assign a32     = 32'(addr);
  assign glb_hit = a32 < 32'(GLB_BYTES);
  assign prf_hit = !glb_hit && (a32 < 32'(MAPPED));
  assign hit     = glb_hit || prf_hit;
  assign lin     = glb_hit ? a32
                 : 32'(GLB_BYTES) + 32'(prof_sel) * 32'(PRF_BYTES) + (a32 - 32'(GLB_BYTES));
  assign idx     = lin[IW-1:0];

  assign wr_ok   = par_mode && wr && !rd && hit;
  assign drv     = par_mode && rd && !wr;
  assign rdata   = hit ? stg[idx] : '0;
  assign data_io = drv ? rdata : 'z;

  assign commit  = (upd_s[1] && !upd_q) || (prf_s2 != act_bank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg      <= '0;
      act      <= '0;
      err      <= 1'b0;
      upd_s    <= '0;
      upd_q    <= 1'b0;
      prf_s1   <= '0;
      prf_s2   <= '0;
      act_bank <= '0;
    end else begin
      upd_s    <= {upd_s[0], upd};
      upd_q    <= upd_s[1];
      prf_s1   <= prof_sel;
      prf_s2   <= prf_s1;
      act_bank <= prf_s2;
      err      <= par_mode && rd && wr;
      if (wr_ok) stg[idx] <= data_io;
      if (commit) act <= stg;
    end
  end

  assign act_glb = act[GLB_BYTES-1:0];

  always_comb begin
    for (int j = 0; j < PRF_BYTES; j++) begin
      act_prf[j*DW +: DW] = act[IW'(GLB_BYTES + int'(act_bank) * PRF_BYTES + j)];
    end
  end
endmodule

module profreg_port_chk #(
  parameter int SW     = 320,
  parameter int GW     = 64,
  parameter int AW     = 6,
  parameter int MAPPED = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          par_mode,
  input logic          rd,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic          err,
  input logic          drv,
  input logic          commit,
  input logic [SW-1:0] stg_v,
  input logic [GW-1:0] act_glb
);
  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_glb));

  // R6
  serial_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_mode |=> $stable(stg_v));

  // R7
  conflict_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && rd && wr) |=> (err && $stable(stg_v)));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(par_mode && rd && wr));

  // R8
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> (par_mode && rd && !wr));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(addr) >= MAPPED) |=> $stable(stg_v));
endmodule

bind profreg_port profreg_port_chk #(
  .SW(NBYTES * DW), .GW(GLB_BYTES * DW), .AW(AW), .MAPPED(MAPPED)
) chk (
  .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .rd(rd), .wr(wr),
  .addr(addr), .err(err), .drv(drv), .commit(commit), .stg_v(stg),
  .act_glb(act_glb)
);

// File: tb/profreg_port_test.sv
`timescale 1ns/1ps
module profreg_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic par_mode = 1'b1, rd = 1'b0, wr = 1'b0, upd = 1'b0;
  logic [5:0] addr = '0;
  logic [1:0] prof_sel = '0;
  logic [7:0] tb_d = '0;
  logic tb_drv = 1'b0;
  wire  [7:0] bus;
  logic err;
  logic [63:0] act_glb, act_prf;
  logic [1:0] act_bank;
  int checks = 0, fails = 0;

  assign bus = tb_drv ? tb_d : 8'hzz;
  always #2 clk = ~clk;

  profreg_port uut (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .rd(rd), .wr(wr),
    .addr(addr), .data_io(bus), .prof_sel(prof_sel), .upd(upd),
    .err(err), .act_glb(act_glb), .act_prf(act_prf), .act_bank(act_bank)
  );

  // table entry: {addr[5:0], prof[1:0], data[7:0]}
  localparam logic [15:0] VEC [0:7] = '{
    {6'h08, 2'd0, 8'hA0}, {6'h08, 2'd1, 8'hA1}, {6'h08, 2'd2, 8'hA2},
    {6'h08, 2'd3, 8'hA3}, {6'h0F, 2'd3, 8'hF3}, {6'h0F, 2'd0, 8'hF0},
    {6'h00, 2'd2, 8'h10}, {6'h07, 2'd1, 8'h17}
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_not(input string tag, input logic [7:0] got, input logic [7:0] bad);
    checks++;
    if (got === bad) begin
      fails++;
      $display("FAIL %s: got %h expected anything but %h", tag, got, bad);
    end
  endtask

  task automatic do_wr(input logic [5:0] a, input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    addr = a; prof_sel = p; tb_d = d; tb_drv = 1'b1; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; tb_drv = 1'b0;
  endtask

  task automatic do_rd(input logic [5:0] a, input logic [1:0] p, output logic [7:0] d);
    @(negedge clk);
    addr = a; prof_sel = p; rd = 1'b1;
    #1 d = bus;
    rd = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 act_glb", act_glb, 64'h0);
    check("R1 act_prf", act_prf, 64'h0);
    check("R1 err", 64'(err), 64'h0);
    check("R1 act_bank", 64'(act_bank), 64'h0);
    do_rd(6'h05, 2'd0, d);
    check("R1 staged zero", 64'(d), 64'h0);

    // R2 staged but not active
    do_wr(6'h02, 2'd0, 8'h5A);
    do_rd(6'h02, 2'd0, d);
    check("R2 readback", 64'(d), 64'h5A);
    check("R2 active unchanged", 64'(act_glb[23:16]), 64'h0);

    // R3 commit latency
    @(negedge clk); upd = 1'b1;
    wait_edges(2);
    check("R3 not after two edges", 64'(act_glb[23:16]), 64'h0);
    wait_edges(1);
    check("R3 after three edges", 64'(act_glb[23:16]), 64'h5A);
    do_wr(6'h03, 2'd0, 8'h11);
    wait_edges(5);
    check("R3 held level no commit", 64'(act_glb[31:24]), 64'h0);
    @(negedge clk); upd = 1'b0;
    wait_edges(5);
    check("R3 falling edge no commit", 64'(act_glb[31:24]), 64'h0);

    // R6 serial mode
    @(negedge clk); par_mode = 1'b0;
    do_wr(6'h04, 2'd0, 8'hEE);
    do_rd(6'h02, 2'd0, d);
    check_not("R6 bus undriven", d, 8'h5A);
    @(negedge clk); par_mode = 1'b1;
    do_rd(6'h04, 2'd0, d);
    check("R6 write ignored", 64'(d), 64'h0);

    // R8 idle bus
    @(negedge clk); addr = 6'h02;
    #1 check_not("R8 idle undriven", bus, 8'h5A);

    // R7 strobe conflict
    @(negedge clk);
    addr = 6'h02; tb_d = 8'hC3; tb_drv = 1'b1; wr = 1'b1; rd = 1'b1;
    @(negedge clk);
    check("R7 err raised", 64'(err), 64'h1);
    wr = 1'b0; rd = 1'b0; tb_drv = 1'b0;
    @(negedge clk);
    check("R7 err cleared", 64'(err), 64'h0);
    do_rd(6'h02, 2'd0, d);
    check("R7 no write", 64'(d), 64'h5A);

    // R9 unmapped
    do_wr(6'h18, 2'd0, 8'h99);
    do_rd(6'h18, 2'd0, d);
    check("R9 unmapped read", 64'(d), 64'h0);
    do_rd(6'h08, 2'd0, d);
    check("R9 no alias profile", 64'(d), 64'h0);
    do_rd(6'h00, 2'd0, d);
    check("R9 no alias global", 64'(d), 64'h0);

    // R5 and R10 table walk
    foreach (VEC[i]) do_wr(VEC[i][15:10], VEC[i][9:8], VEC[i][7:0]);
    foreach (VEC[i]) begin
      do_rd(VEC[i][15:10], VEC[i][9:8], d);
      check("R5 bank readback", 64'(d), 64'(VEC[i][7:0]));
    end
    do_rd(6'h00, 2'd3, d);
    check("R10 global under other bank", 64'(d), 64'h10);
    do_rd(6'h07, 2'd0, d);
    check("R10 global under bank 0", 64'(d), 64'h17);

    // R4 profile change commits
    @(negedge clk); prof_sel = 2'd3;
    wait_edges(5);
    @(negedge clk); prof_sel = 2'd1;
    wait_edges(2);
    check("R4 bank not after two edges", 64'(act_bank), 64'd3);
    check("R4 old bank bytes", 64'(act_prf[7:0]), 64'hA3);
    check("R4 old bank top", 64'(act_prf[63:56]), 64'hF3);
    wait_edges(1);
    check("R4 bank switched", 64'(act_bank), 64'd1);
    check("R4 new bank bytes", 64'(act_prf[7:0]), 64'hA1);
    check("R4 globals committed", 64'(act_glb[7:0]), 64'h10);
    check("R4 global top", 64'(act_glb[63:56]), 64'h17);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears active", act_glb, 64'h0);
    rst_n = 1'b1;
    do_rd(6'h02, 2'd1, d);
    check("R1 reset clears staged", 64'(d), 64'h0);

    finish_run();
  end
endmodule